// File: doc/BRIEF.md
# Tributary Bit-Stuffing Elastic Store

This block carries a single serial tributary (a 1.544 Mbit/s or 2.048 Mbit/s line) across into the clock of the higher-order frame generator. It also decides, at every stuffing opportunity, whether that opportunity holds a stuff bit or a data bit. Bits arrive one at a time with a write enable from the tributary side. The frame generator pulls one bit at a time with a read enable, and it pulses an opportunity strobe once per frame. Both sides are modelled as enables on one clock. The fill level is the difference between the write and read pointers.

A small one-bit-wide ring of 16 entries absorbs the tributary's frequency offset and jitter. The stuffing policy comes from a two-bit mode. In fill-driven mode, a low store asks for a stuff. Always-stuff mode stuffs every opportunity. Fixed-ratio mode stuffs one opportunity in every N. Bypass mode leaves the store idle and passes the input straight through. If the store slips, a sticky flag is raised and the pointers are moved back to the centre.

Top module: `tribElasticStore`

## Requirements
- R1: After reset `rdData`, `stuffReq`, `overflowFlag` and `underflowFlag` are 0. Every entry holds 0 and the write pointer leads the read pointer by 8, so the store starts half full.
- R2: Outside bypass, bits written with `wrEn` are returned by `rdEn` reads in write order. `rdData` is registered and shows the bit one cycle after the read.
- R3: A write with no read while 16 bits are held is dropped. It sets `overflowFlag` and moves the read pointer so that exactly the 8 newest bits remain.
- R4: A read while the store is empty returns `rdData` = 0 and sets `underflowFlag`. It moves the read pointer 8 entries behind the write pointer, and those entries are then read out.
- R5: With `mode` = 0 (fill-driven), an opportunity latches `stuffReq` = 1 if the fill is below 8 and 0 otherwise. The value is visible one cycle later and held until the next opportunity.
- R6: With `mode` = 1 (always stuff), every opportunity latches `stuffReq` = 1.
- R7: With `mode` = 2 (fixed ratio), an opportunity counter that starts at 0 after reset makes every `ratioN`-th opportunity a stuff and all others 0. A `ratioN` of 0 or 1 stuffs every opportunity.
- R8: With `mode` = 3 (bypass), `rdData` equals `wrData` from the previous cycle whatever the enables are. Writes and reads leave the store and both flags untouched, and opportunities latch `stuffReq` = 0.
- R9: `overflowFlag` and `underflowFlag` stay set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both sides |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 fill-driven, 1 always stuff, 2 fixed ratio, 3 bypass |
| ratioN | input | RATIO_W | One stuff every ratioN opportunities in fixed-ratio mode |
| wrEn | input | 1 | Tributary bit valid |
| wrData | input | 1 | Tributary bit |
| rdEn | input | 1 | Frame generator takes one bit |
| rdData | output | 1 | Bit delivered to the frame generator |
| stuffOpp | input | 1 | Stuffing opportunity strobe |
| stuffReq | output | 1 | Latched stuff decision for the current opportunity |
| overflowFlag | output | 1 | Sticky: a write was lost to a full store |
| underflowFlag | output | 1 | Sticky: a read found the store empty |

## Verification
Every result is one register away from the enable that causes it. `rdData`, `stuffReq` and both flags change at the first rising edge after the cycle in which `wrEn`, `rdEn` or `stuffOpp` is held. A decision taken at an opportunity therefore uses the fill from before that cycle's reads and writes. The bench drives each stimulus on a falling edge and samples on the next falling edge, half a period after the edge that registered the result. The expected read sequences after a slip are worked out from the recentring rule: 8 behind the write pointer.

// File: rtl/tes_pkg.sv
package tes_pkg;

  typedef enum logic [1:0] {
    MODE_FILL   = 2'd0,
    MODE_ALWAYS = 2'd1,
    MODE_RATIO  = 2'd2,
    MODE_BYPASS = 2'd3
  } stuffMode_t;

  typedef struct packed {
    logic doWrite;
    logic doRead;
    logic recentre;
    logic zeroData;
    logic bypassData;
  } storeStrobe_t;

endpackage

// File: rtl/tes_datapath.sv
module tes_datapath
  import tes_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  storeStrobe_t               strobe,
  input  logic                       wrData,
  output logic                       rdData,
  output logic [$clog2(DEPTH):0]     fill
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;
  localparam logic [PTR_W-1:0] HALF = PTR_W'(DEPTH / 2);

  logic             mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] wrPtrNext;

  assign wrPtrNext = wrPtr + PTR_W'(strobe.doWrite);
  assign fill      = wrPtr - rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 1'b0;
    end else if (strobe.doWrite) begin
      mem[wrPtr[ADDR_W-1:0]] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= HALF;
      rdPtr  <= '0;
      rdData <= 1'b0;
    end else begin
      wrPtr <= wrPtrNext;
      if (strobe.recentre)    rdPtr <= wrPtrNext - HALF;
      else if (strobe.doRead) rdPtr <= rdPtr + PTR_W'(1);

      if (strobe.bypassData)    rdData <= wrData;
      else if (strobe.zeroData) rdData <= 1'b0;
      else if (strobe.doRead)   rdData <= mem[rdPtr[ADDR_W-1:0]];
    end
  end

endmodule

// File: rtl/tes_control.sv
module tes_control
  import tes_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int RATIO_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  stuffMode_t             mode,
  input  logic [RATIO_W-1:0]     ratioN,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic                   stuffOpp,
  input  logic [$clog2(DEPTH):0] fill,
  output storeStrobe_t           strobe,
  output logic                   stuffReq,
  output logic                   overflowFlag,
  output logic                   underflowFlag
);

  localparam int PTR_W = $clog2(DEPTH) + 1;
  localparam logic [PTR_W-1:0] HALF = PTR_W'(DEPTH / 2);
  localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

  logic               bypass;
  logic               ovfEvent;
  logic               unfEvent;
  logic               decision;
  logic               ratioHit;
  logic [RATIO_W-1:0] oppCnt;

  assign bypass   = (mode == MODE_BYPASS);
  assign ovfEvent = !bypass && wrEn && !rdEn && (fill == FULL);
  assign unfEvent = !bypass && rdEn && (fill == '0);

  always_comb begin
    strobe.doWrite    = !bypass && wrEn && !ovfEvent;
    strobe.doRead     = !bypass && rdEn && !unfEvent;
    strobe.recentre   = ovfEvent || unfEvent;
    strobe.zeroData   = unfEvent;
    strobe.bypassData = bypass;
  end

  assign ratioHit = (ratioN <= RATIO_W'(1)) || (oppCnt >= ratioN - RATIO_W'(1));

  always_comb begin
    unique case (mode)
      MODE_FILL:   decision = (fill < HALF);
      MODE_ALWAYS: decision = 1'b1;
      MODE_RATIO:  decision = ratioHit;
      default:     decision = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stuffReq      <= 1'b0;
      oppCnt        <= '0;
      overflowFlag  <= 1'b0;
      underflowFlag <= 1'b0;
    end else begin
      if (stuffOpp) begin
        stuffReq <= decision;
        if (mode == MODE_RATIO) oppCnt <= ratioHit ? '0 : oppCnt + RATIO_W'(1);
      end
      if (ovfEvent) overflowFlag  <= 1'b1;
      if (unfEvent) underflowFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/tribElasticStore.sv
module tribElasticStore
  import tes_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         mode,
  input  logic [RATIO_W-1:0] ratioN,
  input  logic               wrEn,
  input  logic               wrData,
  input  logic               rdEn,
  output logic               rdData,
  input  logic               stuffOpp,
  output logic               stuffReq,
  output logic               overflowFlag,
  output logic               underflowFlag
);

  localparam int PTR_W = $clog2(DEPTH) + 1;

  storeStrobe_t     strobe;
  logic [PTR_W-1:0] fill;

  tes_control #(.DEPTH(DEPTH), .RATIO_W(RATIO_W)) uCtrl (
    .clk(clk), .rstN(rstN), .mode(stuffMode_t'(mode)), .ratioN(ratioN),
    .wrEn(wrEn), .rdEn(rdEn), .stuffOpp(stuffOpp), .fill(fill),
    .strobe(strobe), .stuffReq(stuffReq),
    .overflowFlag(overflowFlag), .underflowFlag(underflowFlag)
  );

  tes_datapath #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdData(rdData), .fill(fill)
  );

endmodule

// File: rtl/tes_checker.sv
module tes_checker #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [1:0]             mode,
  input logic                   wrEn,
  input logic                   wrData,
  input logic                   rdEn,
  input logic                   rdData,
  input logic                   stuffOpp,
  input logic                   stuffReq,
  input logic                   overflowFlag,
  input logic                   underflowFlag,
  input logic [$clog2(DEPTH):0] fill
);

  localparam int PTR_W = $clog2(DEPTH) + 1;
  localparam logic [PTR_W-1:0] HALF = PTR_W'(DEPTH / 2);
  localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    fill <= FULL);

  p_overflow_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'd3 && wrEn && !rdEn && fill == FULL) |=> (overflowFlag && fill == HALF));

  p_underflow_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'd3 && rdEn && fill == '0) |=> (underflowFlag && !rdData && fill == HALF));

  p_fill_stuff_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stuffOpp && mode == 2'd0) |=> (stuffReq == ($past(fill) < HALF)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !stuffOpp |=> $stable(stuffReq));

  p_always_stuff_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stuffOpp && mode == 2'd1) |=> stuffReq);

  p_bypass_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3) |=> (rdData == $past(wrData) && $stable(fill)));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  p_unf_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    underflowFlag |=> underflowFlag);

endmodule

bind tribElasticStore tes_checker #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .mode(mode), .wrEn(wrEn), .wrData(wrData),
  .rdEn(rdEn), .rdData(rdData), .stuffOpp(stuffOpp), .stuffReq(stuffReq),
  .overflowFlag(overflowFlag), .underflowFlag(underflowFlag), .fill(fill)
);

// File: tb/sim_tribElasticStore.sv
module sim_tribElasticStore;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] ratioN = 8'd0;
  logic       wrEn = 1'b0, wrData = 1'b0, rdEn = 1'b0, stuffOpp = 1'b0;
  logic       rdData, stuffReq, overflowFlag, underflowFlag;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  tribElasticStore #(.DEPTH(16), .RATIO_W(8)) u0 (
    .clk(clk), .rstN(rstN), .mode(mode), .ratioN(ratioN),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .stuffOpp(stuffOpp), .stuffReq(stuffReq),
    .overflowFlag(overflowFlag), .underflowFlag(underflowFlag)
  );

  // {mode[15:14], ratioN[13:6], expected stuffReq for opportunities 1..6 in [5:0], opp 1 at bit 5}
  localparam logic [15:0] VEC [7] = '{
    {2'd0, 8'd0, 6'b000000},   // R5 fill 8 after reset: no stuff
    {2'd1, 8'd5, 6'b111111},   // R6
    {2'd2, 8'd3, 6'b001001},   // R7
    {2'd2, 8'd2, 6'b010101},   // R7
    {2'd2, 8'd1, 6'b111111},   // R7
    {2'd2, 8'd0, 6'b111111},   // R7
    {2'd3, 8'd0, 6'b000000}    // R8
  };

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic wd, input logic re, input logic opp);
    wrEn = we; wrData = wd; rdEn = re; stuffOpp = opp;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; stuffOpp = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [3:0] pat;
    logic [7:0] afterUnf;
    pat      = 4'b1011;
    afterUnf = 8'b0000_1011;
    @(negedge clk);
    doReset();
    // R1 reset state
    check("R1 rdData", rdData, 1'b0);
    check("R1 stuffReq", stuffReq, 1'b0);
    check("R1 overflowFlag", overflowFlag, 1'b0);
    check("R1 underflowFlag", underflowFlag, 1'b0);

    // stuffing policy table
    for (int v = 0; v < 7; v++) begin
      mode = VEC[v][15:14];
      ratioN = VEC[v][13:6];
      doReset();
      for (int k = 0; k < 6; k++) begin
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check($sformatf("R5/R6/R7/R8 vec %0d opp %0d", v, k), stuffReq, VEC[v][5-k]);
      end
    end

    // R2 ordering, R5 decisions, R4 underflow
    mode = 2'd0;
    doReset();
    for (int i = 3; i >= 0; i--) step(1'b1, pat[i], 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    check("R5 fill 12 no stuff", stuffReq, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 held between opportunities", stuffReq, 1'b0);
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'b0, 1'b1, 1'b0);
      check("R1 initial half-full zeros", rdData, 1'b0);
    end
    for (int i = 3; i >= 0; i--) begin
      step(1'b0, 1'b0, 1'b1, 1'b0);
      check("R2 write order", rdData, pat[i]);
    end
    check("R1 no underflow after 12 reads", underflowFlag, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    check("R5 empty stuff", stuffReq, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    check("R4 underflow flag", underflowFlag, 1'b1);
    check("R4 underflow data", rdData, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    check("R4 recentred fill 8 no stuff", stuffReq, 1'b0);
    for (int i = 7; i >= 0; i--) begin
      step(1'b0, 1'b0, 1'b1, 1'b0);
      check("R4 data after recentre", rdData, afterUnf[i]);
    end
    check("R4 overflow untouched", overflowFlag, 1'b0);

    // R3 overflow and R9 sticky
    doReset();
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
    check("R3 full not overflow", overflowFlag, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    check("R3 overflow flag", overflowFlag, 1'b1);
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'b0, 1'b1, 1'b0);
      check("R3 newest 8 kept, dropped bit absent", rdData, 1'b1);
    end
    check("R3 no underflow", underflowFlag, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    check("R5 empty after overflow drain", stuffReq, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check("R9 overflow sticky", overflowFlag, 1'b1);
    check("R9 underflow sticky", underflowFlag, 1'b1);

    // R8 bypass
    mode = 2'd3;
    doReset();
    step(1'b1, 1'b1, 1'b0, 1'b0);
    check("R8 pass 1", rdData, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 pass 0", rdData, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    check("R8 pass without wrEn", rdData, 1'b1);
    for (int i = 0; i < 9; i++) step(1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 9; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
    check("R8 no underflow", underflowFlag, 1'b0);
    check("R8 no overflow", overflowFlag, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    check("R8 stuffReq 0", stuffReq, 1'b0);
    mode = 2'd0;
    step(1'b0, 1'b0, 1'b0, 1'b1);
    check("R8 store still half full", stuffReq, 1'b0);
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'b0, 1'b1, 1'b0);
      check("R8 bypass writes not stored", rdData, 1'b0);
    end
    check("R8 no underflow at 8", underflowFlag, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    check("R8 underflow at 9th read", underflowFlag, 1'b1);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule